// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block takes a one-bit serial stream, sampled on every rising edge of a fast serial clock, and assembles it into 16-bit parallel words. The bit that arrives first in time appears on the most significant output bit. Each new word is released together with a divided parallel clock and a one-cycle word-valid strobe. The parallel clock is produced as a registered square wave in the serial-clock domain.

Framing logic that searches for a word boundary uses the slip input. When this input stays high for at least four consecutive serial cycles, the divider is held for one serial cycle. That word period then lasts 17 serial cycles and its oldest bit is discarded, so the word boundary moves one bit later in the stream. A single qualifying pulse gives exactly one slip, however long it stays high. Electrical buffering and clock recovery are not part of this block.

Top module: `bitslip_deser`

## Requirements
- R1: On every non-reset rising edge of `clk`, `sdi` is shifted in. A released word holds the last 16 received bits. The oldest of them is on `pdata[15]` and the newest on `pdata[0]`.
- R2: `pclk` is low for 8 serial cycles and then high for 8. `pdata` changes only in the cycle in which `pclk` rises.
- R3: Without slips, exactly one word is released every 16 serial cycles.
- R4: When `sync` is high for at least 4 consecutive serial cycles, exactly one word period lasts 17 cycles. The word released at its end is the 16 newest bits, so the oldest bit of that period is dropped.
- R5: The 17-cycle word is released no more than 32 serial cycles after the first cycle in which `sync` is sampled high.
- R6: A `sync` pulse of 1 to 3 cycles causes no slip.
- R7: A `sync` level held high for many cycles causes only one slip. A further slip needs `sync` to go low and then rise again.
- R8: A synchronous active-high `rst` clears the shift register, the divider and the output word. While in reset, `pdata` is 0, `pclk` is low and `pvld` is low.
- R9: `pvld` is high for exactly one cycle per released word, including a slipped word, and only in the cycle where `pclk` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; every flop uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data bit |
| sync | input | 1 | Slip request; it must be high for at least 4 cycles to qualify |
| pdata | output | 16 | Registered parallel word, MSB received first |
| pclk | output | 1 | Divided parallel clock, 50% duty cycle |
| pvld | output | 1 | One-cycle strobe marking a new word |

## Verification
A word released on an edge appears at `pdata`, `pclk` and `pvld` right after that edge, because there is one register between the inputs and each output. A qualifying `sync` sets the slip request four edges after the rise. The held divider cycle follows at the next word boundary, so the stretched word appears between 4 and about 21 cycles after the rise. The bench drives inputs on the falling edge and feeds the same values to its reference model. It compares the model's state with the outputs at the next falling edge, half a cycle after the edge that registered them. It also measures the spacing between strobes to check the slip count and its latency.

// File: rtl/bs_pkg.sv
package bs_pkg;
    // Default word width and minimum slip-request run length
    parameter int unsigned BS_WORD_W_DEF   = 16;
    parameter int unsigned BS_SYNC_MIN_DEF = 4;

    // Phase of the parallel clock, derived from the divider count
    typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} pclk_phase_e;
endpackage

// File: rtl/bs_sync_qual.sv
module bs_sync_qual #(
    parameter int unsigned MIN_HIGH = bs_pkg::BS_SYNC_MIN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    input  logic take_i,
    output logic pend_o
);
    localparam int unsigned RW = $clog2(MIN_HIGH + 1);

    typedef struct packed {
        logic [RW-1:0] run;
        logic          pend;
    } st_t;

    st_t st_d, st_q;
    logic qual;

    always_comb begin
        st_d = st_q;
        // The run saturates at MIN_HIGH, so MIN_HIGH-1 is passed once per high level
        qual = sync_i && (st_q.run == RW'(MIN_HIGH - 1));
        if (!sync_i) begin
            st_d.run = '0;
        end else if (st_q.run != RW'(MIN_HIGH)) begin
            st_d.run = st_q.run + 1'b1;
        end
        st_d.pend = (st_q.pend && !take_i) || qual;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/bs_divider.sv
module bs_divider #(
    parameter int unsigned W = bs_pkg::BS_WORD_W_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic pend_i,
    output logic take_o,
    output logic latch_o,
    output logic pclk_o
);
    import bs_pkg::*;

    localparam int unsigned CW   = $clog2(W);
    localparam int unsigned HALF = W / 2;
    localparam logic [CW-1:0] EDGE_AT = CW'(HALF - 1);
    localparam logic [CW-1:0] LAST    = CW'(W - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        pclk_phase_e   ph;
    } st_t;

    st_t st_d, st_q;
    logic at_edge;

    always_comb begin
        st_d    = st_q;
        at_edge = (st_q.cnt == EDGE_AT);
        take_o  = at_edge && pend_i;
        latch_o = at_edge && !pend_i;
        if (!take_o) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
        st_d.ph = (st_d.cnt >= CW'(HALF)) ? PH_HIGH : PH_LOW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{cnt: '0, ph: PH_LOW};
        end else begin
            st_q <= st_d;
        end
    end

    assign pclk_o = (st_q.ph == PH_HIGH);
endmodule

// File: rtl/bs_shifter.sv
module bs_shifter #(
    parameter int unsigned W = bs_pkg::BS_WORD_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sdi_i,
    input  logic         latch_i,
    output logic [W-1:0] word_o,
    output logic         vld_o
);
    typedef struct packed {
        logic [W-1:0] sr;
        logic [W-1:0] word;
        logic         vld;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sr  = {st_q.sr[W-2:0], sdi_i};
        st_d.vld = latch_i;
        if (latch_i) begin
            st_d.word = st_d.sr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
    assign vld_o  = st_q.vld;
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
    parameter int unsigned WORD_W   = bs_pkg::BS_WORD_W_DEF,
    parameter int unsigned SYNC_MIN = bs_pkg::BS_SYNC_MIN_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi,
    input  logic              sync,
    output logic [WORD_W-1:0] pdata,
    output logic              pclk,
    output logic              pvld
);
    logic pend;
    logic take;
    logic latch;

    bs_sync_qual #(.MIN_HIGH(SYNC_MIN)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync),
        .take_i (take),
        .pend_o (pend)
    );

    bs_divider #(.W(WORD_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .pend_i  (pend),
        .take_o  (take),
        .latch_o (latch),
        .pclk_o  (pclk)
    );

    bs_shifter #(.W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .sdi_i   (sdi),
        .latch_i (latch),
        .word_o  (pdata),
        .vld_o   (pvld)
    );
endmodule

// File: rtl/bs_deser_chk.sv
module bs_deser_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] pdata,
    input logic         pclk,
    input logic         pvld
);
    logic live_q = 1'b0;
    always_ff @(posedge clk) live_q <= !rst;

    // R8: one edge into reset, all outputs are cleared
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (pdata == '0 && !pclk && !pvld));

    // R9: the strobe coincides with a rising parallel clock
    a_r9_vld_on_rise: assert property (@(posedge clk) disable iff (rst || !live_q)
        pvld |-> $rose(pclk));

    // R2: every rising parallel clock carries a strobe
    a_r2_rise_has_vld: assert property (@(posedge clk) disable iff (rst || !live_q)
        $rose(pclk) |-> pvld);

    // R2: the word holds still between strobes
    a_r2_word_stable: assert property (@(posedge clk) disable iff (rst || !live_q)
        !pvld |-> $stable(pdata));

    // R9: the strobe lasts a single cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst || !live_q)
        pvld |=> !pvld);
endmodule

bind bitslip_deser bs_deser_chk #(.W(WORD_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .pdata (pdata),
    .pclk  (pclk),
    .pvld  (pvld)
);

// File: tb/bitslip_deser_bench.sv
module bitslip_deser_bench;
    localparam int W = 16;
    localparam int MINH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sdi = 1'b0;
    logic sync = 1'b0;
    logic [W-1:0] pdata;
    logic pclk, pvld;

    always #2 clk = ~clk;

    bitslip_deser u_bitslip_deser (
        .clk(clk), .rst(rst), .sdi(sdi), .sync(sync),
        .pdata(pdata), .pclk(pclk), .pvld(pvld)
    );

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state (value expected after the last edge)
    bit hist[$];
    int ph = 0, run = 0;
    bit pend = 0;
    logic [W-1:0] e_dout = '0;
    bit e_pclk = 0, e_vld = 0;
    bit primed = 0;

    // Strobe spacing statistics
    int gap = 0, n16 = 0, n17 = 0, nother = 0;
    bit seen_vld = 0;
    int step_no = 0, last17_step = -1;

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s step %0d: actual %0h expected %0h", req, step_no, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model_word();
        logic [W-1:0] w = '0;
        for (int i = 0; i < W; i++) begin
            int idx = hist.size() - W + i;
            if (idx >= 0) w[W-1-i] = hist[idx];
        end
        return w;
    endfunction

    task automatic model_edge(bit d, bit s, bit r);
        if (r) begin
            hist.delete();
            ph = 0; run = 0; pend = 0;
            e_dout = '0; e_pclk = 0; e_vld = 0;
        end else begin
            bit at7, hold, lat, qual;
            hist.push_back(d);
            if (hist.size() > W) void'(hist.pop_front());
            at7  = (ph == W / 2 - 1);
            hold = pend && at7;
            lat  = at7 && !hold;
            qual = s && (run == MINH - 1);
            run  = s ? ((run < MINH) ? run + 1 : run) : 0;
            pend = (pend && !hold) || qual;
            if (!hold) ph = (ph + 1) % W;
            e_pclk = (ph >= W / 2);
            e_vld  = lat;
            if (lat) e_dout = model_word();
        end
    endtask

    // One serial cycle: compare at the falling edge, then drive the next inputs
    task automatic step(bit d, bit s, bit r);
        @(negedge clk);
        if (primed) begin
            check("R1", pdata, e_dout);
            check("R2", pclk, e_pclk);
            check("R9", pvld, e_vld);
            gap++;
            if (pvld === 1'b1) begin
                if (seen_vld) begin
                    if (gap == 16) n16++;
                    else if (gap == 17) begin n17++; last17_step = step_no; end
                    else nother++;
                end
                seen_vld = 1;
                gap = 0;
            end
        end
        primed = 1;
        step_no++;
        sdi = d; sync = s; rst = r;
        model_edge(d, s, r);
    endtask

    task automatic clear_stats();
        n16 = 0; n17 = 0; nother = 0;
    endtask

    task automatic run_cycles(int n, bit s);
        for (int i = 0; i < n; i++) step(1'($urandom), s, 1'b0);
    endtask

    initial begin
        int rise;
        // R8: reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check("R8", pdata, 0);
        check("R8", pclk, 0);
        check("R8", pvld, 0);

        // R1/R3: free-running capture, random then fixed patterns
        run_cycles(8, 1'b0);
        clear_stats();
        run_cycles(100, 1'b0);
        for (int i = 0; i < 32; i++) step(1'(i % 3 == 0), 1'b0, 1'b0);
        check("R3", n17, 0);
        check("R3", nother, 0);
        check("R3", int'(n16 >= 7), 1);

        // R4/R5: minimum-width slip request
        clear_stats();
        rise = step_no;
        run_cycles(MINH, 1'b1);
        run_cycles(60, 1'b0);
        check("R4", n17, 1);
        check("R4", nother, 0);
        check("R5", int'(last17_step - rise <= 32), 1);

        // R6: pulses that are too short
        for (int k = 1; k < MINH; k++) begin
            clear_stats();
            run_cycles(k, 1'b1);
            run_cycles(40, 1'b0);
            check("R6", n17 + nother, 0);
        end

        // R7: a long level slips once; low-then-high slips again
        clear_stats();
        run_cycles(70, 1'b1);
        check("R7", n17, 1);
        run_cycles(10, 1'b0);
        clear_stats();
        run_cycles(5, 1'b1);
        run_cycles(40, 1'b0);
        check("R7", n17, 1);
        check("R7", nother, 0);

        // R8: reset in the middle of a word
        run_cycles(5, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check("R8", pdata, 0);
        check("R8", pclk, 0);
        seen_vld = 0;
        run_cycles(40, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule